// File: doc/BRIEF.md
# Transmit Overhead Byte Selector

This block picks the value of each transport overhead byte as an outgoing STS-3/STM-1 frame is built. The frame builder presents a row and column for each overhead position. For that position the block chooses one of three sources: the byte on an external overhead access channel, a per-byte register value (S1 and F1 only), or a common default byte. The result appears on the output one clock later. Framing and pointer positions, and positions outside the 9x9 overhead area, are flagged as not driven by this block.

A group of enable bits decides which byte groups take the access-channel byte. A restricted mode lets the channel feed only the first three data communication bytes. A parity monitor checks every access-channel byte that arrives, using odd or even parity as configured, and reports each failure as a one-cycle pulse. The control word is captured into a register on a load strobe. That register clears to zero on reset, so after reset every byte the block drives takes the default.

Top module: `toh_sel`

## Requirements
- R1: The output is registered with one cycle of latency. `oh_vld_o` is 0 and `oh_byte_o` is 0 in three cases: `pos_vld_i` is low, the row or column lies outside 1..9, or the position is a framing/pointer byte. The framing/pointer bytes are row 1 columns 1-2, row 2 column 1, rows 4-5 columns 1-3, and columns 4-9 of rows 1, 4 and 5. Every other in-range position gives `oh_vld_o`=1.
- R2: Row 3, columns 1-3 (D1-D3) output the access-channel byte when `cfg_i[1]` is set, and the default byte otherwise.
- R3: Rows 6-8, columns 1-3 (D4-D12) output the access-channel byte when `cfg_i[2]` is set and restricted mode is off, and the default byte otherwise.
- R4: E1 (row 2, column 2) follows enable `cfg_i[3]`. E2 (row 9, column 3) follows enable `cfg_i[4]`. Each takes the access-channel byte when its enable is set and restricted mode is off, and the default byte otherwise.
- R5: S1 (row 9, column 1) outputs `s1_reg_i` when `cfg_i[9]` is set. Otherwise it outputs the access-channel byte when `cfg_i[6]` is set and restricted mode is off. Otherwise it outputs the default byte.
- R6: F1 (row 2, column 3) follows the same priority as S1. Register value `f1_reg_i` is selected by `cfg_i[10]`, and the access enable is `cfg_i[5]`.
- R7: Columns 4-9 of rows 2, 3 and 6-9 are unassigned positions. They output the access-channel byte when `cfg_i[7]` is set and restricted mode is off, and the default byte otherwise.
- R8: Row 1 column 3 and row 9 column 2 always output the default byte.
- R9: When restricted mode `cfg_i[8]` is set, only D1-D3 can take the access-channel byte. Register insertion of S1 and F1 is unaffected.
- R10: When `oac_vld_i` is high, `par_err_o` pulses one cycle later if the XOR of `oac_byte_i` and `oac_par_i` differs from `cfg_i[0]` (1 = odd parity expected, 0 = even). Otherwise `par_err_o` is 0.
- R11: `cfg_i` is captured on a clock edge with `cfg_ld_i` high, and the captured word applies from the next cycle. On reset the control word is zero, every driven byte takes the default, and the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ld_i | input | 1 | Load strobe for the control word |
| cfg_i | input | 11 | Control word (bit map in R2-R10) |
| s1_reg_i | input | 8 | Register value for S1 |
| f1_reg_i | input | 8 | Register value for F1 |
| dflt_i | input | 8 | Default byte |
| pos_vld_i | input | 1 | Row/column presented this cycle |
| row_i | input | 4 | Overhead row, 1..9 |
| col_i | input | 4 | Overhead column, 1..9 |
| oac_byte_i | input | 8 | Access-channel byte |
| oac_par_i | input | 1 | Access-channel parity bit |
| oac_vld_i | input | 1 | Access-channel byte valid |
| oh_byte_o | output | 8 | Selected overhead byte |
| oh_vld_o | output | 1 | Byte is driven by this block |
| par_err_o | output | 1 | Parity failure pulse |

## Verification
The assertions assume that the access-channel byte and the register and default values are steady for the cycle in which the frame builder presents a position. They also assume a new control word takes effect only after its load edge, so a check that depends on the control word reads the captured register rather than `cfg_i`. The stimulus keeps to this by changing inputs only between edges and by raising `cfg_ld_i` only in dedicated load cycles. Random positions include rows and columns 0 and 10, so the out-of-range cases are covered as well.

// File: rtl/toh_sel_pkg.sv
package toh_sel_pkg;
  typedef enum logic [3:0] {
    CLS_FRM, CLS_FIX, CLS_D13, CLS_D412, CLS_E1, CLS_E2, CLS_S1, CLS_F1, CLS_AVL
  } toh_cls_e;

  typedef struct packed {
    logic f1_ins;
    logic s1_ins;
    logic d13_only;
    logic en_avl;
    logic en_s1;
    logic en_f1;
    logic en_e2;
    logic en_e1;
    logic en_d412;
    logic en_d13;
    logic par_odd;
  } toh_cfg_t;

  localparam int CFG_W = $bits(toh_cfg_t);
endpackage

// File: rtl/toh_pos_dec.sv
module toh_pos_dec
  import toh_sel_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output toh_cls_e         cls_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(9);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(9);
  localparam logic [COL_W-1:0] COL_STS1 = COL_W'(3);

  logic in_rng;
  assign in_rng = (row_i != '0) && (row_i <= ROW_MAX) &&
                  (col_i != '0) && (col_i <= COL_MAX);

  always_comb begin
    cls_o = CLS_FRM;
    if (in_rng) begin
      if (col_i > COL_STS1) begin
        cls_o = (row_i == ROW_W'(1) || row_i == ROW_W'(4) || row_i == ROW_W'(5))
                ? CLS_FRM : CLS_AVL;
      end else begin
        unique case (row_i)
          ROW_W'(1): cls_o = (col_i == COL_W'(3)) ? CLS_FIX : CLS_FRM;
          ROW_W'(2): begin
            if (col_i == COL_W'(2))      cls_o = CLS_E1;
            else if (col_i == COL_W'(3)) cls_o = CLS_F1;
            else                         cls_o = CLS_FRM;
          end
          ROW_W'(3): cls_o = CLS_D13;
          ROW_W'(6), ROW_W'(7), ROW_W'(8): cls_o = CLS_D412;
          ROW_W'(9): begin
            if (col_i == COL_W'(1))      cls_o = CLS_S1;
            else if (col_i == COL_W'(2)) cls_o = CLS_FIX;
            else                         cls_o = CLS_E2;
          end
          default: cls_o = CLS_FRM;
        endcase
      end
    end
  end
endmodule

// File: rtl/toh_src_sel.sv
module toh_src_sel
  import toh_sel_pkg::*;
#(
  parameter int DW = 8
) (
  input  toh_cls_e         cls_i,
  input  toh_cfg_t         cfg_i,
  input  logic [DW-1:0]    oac_i,
  input  logic [DW-1:0]    s1_reg_i,
  input  logic [DW-1:0]    f1_reg_i,
  input  logic [DW-1:0]    dflt_i,
  output logic [DW-1:0]    byte_o,
  output logic             vld_o
);
  // full access: every group may use the channel; restricted: D1-D3 only
  logic full;
  assign full = !cfg_i.d13_only;

  always_comb begin
    vld_o  = 1'b1;
    byte_o = dflt_i;
    unique case (cls_i)
      CLS_FRM: begin
        vld_o  = 1'b0;
        byte_o = '0;
      end
      CLS_FIX:  byte_o = dflt_i;
      CLS_D13:  byte_o = cfg_i.en_d13 ? oac_i : dflt_i;
      CLS_D412: byte_o = (cfg_i.en_d412 && full) ? oac_i : dflt_i;
      CLS_E1:   byte_o = (cfg_i.en_e1 && full) ? oac_i : dflt_i;
      CLS_E2:   byte_o = (cfg_i.en_e2 && full) ? oac_i : dflt_i;
      CLS_AVL:  byte_o = (cfg_i.en_avl && full) ? oac_i : dflt_i;
      CLS_S1: begin
        if (cfg_i.s1_ins)                  byte_o = s1_reg_i;
        else if (cfg_i.en_s1 && full)      byte_o = oac_i;
        else                               byte_o = dflt_i;
      end
      CLS_F1: begin
        if (cfg_i.f1_ins)                  byte_o = f1_reg_i;
        else if (cfg_i.en_f1 && full)      byte_o = oac_i;
        else                               byte_o = dflt_i;
      end
      default: begin
        vld_o  = 1'b0;
        byte_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/toh_par_mon.sv
module toh_par_mon #(
  parameter int DW = 8
) (
  input  logic          vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          par_i,
  input  logic          odd_i,
  output logic          err_o
);
  logic ones_odd;
  assign ones_odd = ^{byte_i, par_i};
  assign err_o    = vld_i && (ones_odd != odd_i);
endmodule

// File: rtl/toh_sel.sv
module toh_sel
  import toh_sel_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ld_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [DW-1:0]    s1_reg_i,
  input  logic [DW-1:0]    f1_reg_i,
  input  logic [DW-1:0]    dflt_i,
  input  logic             pos_vld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DW-1:0]    oac_byte_i,
  input  logic             oac_par_i,
  input  logic             oac_vld_i,
  output logic [DW-1:0]    oh_byte_o,
  output logic             oh_vld_o,
  output logic             par_err_o
);
  toh_cfg_t      cfg_q;
  toh_cls_e      cls;
  logic [DW-1:0] sel_byte;
  logic          sel_vld;
  logic          par_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_ld_i) cfg_q <= toh_cfg_t'(cfg_i);
  end

  toh_pos_dec #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .row_i (row_i),
    .col_i (col_i),
    .cls_o (cls)
  );

  toh_src_sel #(.DW(DW)) u_sel (
    .cls_i    (cls),
    .cfg_i    (cfg_q),
    .oac_i    (oac_byte_i),
    .s1_reg_i (s1_reg_i),
    .f1_reg_i (f1_reg_i),
    .dflt_i   (dflt_i),
    .byte_o   (sel_byte),
    .vld_o    (sel_vld)
  );

  toh_par_mon #(.DW(DW)) u_par (
    .vld_i  (oac_vld_i),
    .byte_i (oac_byte_i),
    .par_i  (oac_par_i),
    .odd_i  (cfg_q.par_odd),
    .err_o  (par_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oh_byte_o <= '0;
      oh_vld_o  <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      oh_vld_o  <= pos_vld_i && sel_vld;
      oh_byte_o <= (pos_vld_i && sel_vld) ? sel_byte : '0;
      par_err_o <= par_err;
    end
  end
endmodule

// File: rtl/toh_sel_chk.sv
module toh_sel_chk
  import toh_sel_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pos_vld_i,
  input logic [ROW_W-1:0] row_i,
  input logic [COL_W-1:0] col_i,
  input logic             oac_vld_i,
  input logic [DW-1:0]    s1_reg_i,
  input logic [DW-1:0]    dflt_i,
  input logic [DW-1:0]    oh_byte_o,
  input logic             oh_vld_o,
  input logic             par_err_o,
  input toh_cfg_t         cfg_q
);
  logic in_rng;
  assign in_rng = (row_i != '0) && (row_i <= ROW_W'(9)) &&
                  (col_i != '0) && (col_i <= COL_W'(9));

  // R1
  idle_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pos_vld_i |=> !oh_vld_o);

  // R1
  ptr_row_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_i == ROW_W'(4)) |=> !oh_vld_o);

  // R1
  invalid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oh_vld_o |-> (oh_byte_o == '0));

  // R5
  s1_reg_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_vld_i && row_i == ROW_W'(9) && col_i == COL_W'(1) && cfg_q.s1_ins)
    |=> (oh_vld_o && oh_byte_o == $past(s1_reg_i)));

  // R9
  d13_only_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_vld_i && in_rng && row_i == ROW_W'(6) && cfg_q.d13_only)
    |=> (oh_byte_o == $past(dflt_i)));

  // R10
  no_par_err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oac_vld_i |=> !par_err_o);

  // R8
  fixed_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_vld_i && row_i == ROW_W'(9) && col_i == COL_W'(2))
    |=> (oh_vld_o && oh_byte_o == $past(dflt_i)));
endmodule

bind toh_sel toh_sel_chk #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pos_vld_i (pos_vld_i),
  .row_i     (row_i),
  .col_i     (col_i),
  .oac_vld_i (oac_vld_i),
  .s1_reg_i  (s1_reg_i),
  .dflt_i    (dflt_i),
  .oh_byte_o (oh_byte_o),
  .oh_vld_o  (oh_vld_o),
  .par_err_o (par_err_o),
  .cfg_q     (cfg_q)
);

// File: tb/toh_sel_tb.sv
module toh_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_ld_i = 1'b0;
  logic [10:0] cfg_i = '0;
  logic [7:0]  s1_reg_i = 8'h11, f1_reg_i = 8'h22, dflt_i = 8'hA3;
  logic        pos_vld_i = 1'b0;
  logic [3:0]  row_i = '0, col_i = '0;
  logic [7:0]  oac_byte_i = '0;
  logic        oac_par_i = 1'b0, oac_vld_i = 1'b0;
  logic [7:0]  oh_byte_o;
  logic        oh_vld_o, par_err_o;

  int n_chk = 0, n_bad = 0;
  logic [10:0] cfg_m = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  toh_sel u_dut (.*);

  // class codes: 0 frm, 1 fix, 2 d13, 3 d412, 4 e1, 5 e2, 6 s1, 7 f1, 8 avl
  function automatic int pos_cls(int r, int k);
    if (r < 1 || r > 9 || k < 1 || k > 9) return 0;
    if (k > 3) return (r == 1 || r == 4 || r == 5) ? 0 : 8;
    case (r)
      1: return (k == 3) ? 1 : 0;
      2: return (k == 1) ? 0 : (k == 2) ? 4 : 7;
      3: return 2;
      6, 7, 8: return 3;
      9: return (k == 1) ? 6 : (k == 2) ? 1 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic string cls_req(int c);
    case (c)
      0: return "R1";
      1: return "R8";
      2: return "R2";
      3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  // returns {vld, byte}
  function automatic logic [8:0] model(logic [10:0] c, int cl, logic pv,
                                       logic [7:0] oac, logic [7:0] s1,
                                       logic [7:0] f1, logic [7:0] df);
    logic full;
    full = !c[8];
    if (!pv || cl == 0) return 9'h000;
    case (cl)
      1: return {1'b1, df};
      2: return {1'b1, c[1] ? oac : df};
      3: return {1'b1, (c[2] && full) ? oac : df};
      4: return {1'b1, (c[3] && full) ? oac : df};
      5: return {1'b1, (c[4] && full) ? oac : df};
      6: return {1'b1, c[9] ? s1 : ((c[6] && full) ? oac : df)};
      7: return {1'b1, c[10] ? f1 : ((c[5] && full) ? oac : df)};
      default: return {1'b1, (c[7] && full) ? oac : df};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(logic [10:0] c);
    cfg_i = c;
    cfg_ld_i = 1'b1;
    @(posedge clk_i); #1;
    cfg_ld_i = 1'b0;
    cfg_m = c;
  endtask

  task automatic step(int r, int k, logic pv, logic [7:0] oac, logic par,
                      logic ov, string req_ovr);
    logic [8:0] exp;
    int cl;
    string req;
    row_i = 4'(r); col_i = 4'(k); pos_vld_i = pv;
    oac_byte_i = oac; oac_par_i = par; oac_vld_i = ov;
    cl = pos_cls(r, k);
    exp = model(cfg_m, cl, pv, oac, s1_reg_i, f1_reg_i, dflt_i);
    req = (req_ovr != "") ? req_ovr : cls_req(cl);
    @(posedge clk_i); #1;
    check(req, {23'd0, oh_vld_o, oh_byte_o}, {23'd0, exp});
    check("R10", {31'd0, par_err_o},
          {31'd0, ov && ((^{oac, par}) != cfg_m[0])});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3 + 1);
    // R11: reset state
    check("R11", {30'd0, oh_vld_o, par_err_o}, 32'd0);
    check("R11", {24'd0, oh_byte_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R11: all positions default after reset, oac ignored
    for (int r = 0; r <= 10; r++)
      for (int k = 0; k <= 10; k++)
        step(r, k, 1'b1, 8'h5C, 1'b0, 1'b0, (pos_cls(r, k) == 0) ? "R1" : "R11");

    // R1: pos_vld low on a driven position
    step(3, 1, 1'b0, 8'h5C, 1'b0, 1'b0, "R1");

    // full enables, no register insert
    load_cfg(11'b000_1111_1110);
    for (int r = 1; r <= 9; r++)
      for (int k = 1; k <= 9; k++)
        step(r, k, 1'b1, 8'(r * 16 + k), 1'b0, 1'b0, "");

    // R5/R6: register insert wins over channel
    load_cfg(11'b110_1111_1110);
    step(9, 1, 1'b1, 8'hE7, 1'b0, 1'b0, "R5");
    step(2, 3, 1'b1, 8'hE7, 1'b0, 1'b0, "R6");

    // R9: restricted mode
    load_cfg(11'b001_1111_1110);
    step(3, 2, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    step(7, 1, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    step(2, 2, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    step(9, 1, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    step(6, 5, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    load_cfg(11'b111_1111_1110);
    step(9, 1, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");
    step(2, 3, 1'b1, 8'h3C, 1'b0, 1'b0, "R9");

    // R10: parity even then odd
    load_cfg(11'b000_0000_0000);
    step(1, 1, 1'b0, 8'h01, 1'b1, 1'b1, "R10");
    step(1, 1, 1'b0, 8'h01, 1'b0, 1'b1, "R10");
    step(1, 1, 1'b0, 8'h01, 1'b0, 1'b0, "R10");
    load_cfg(11'b000_0000_0001);
    step(1, 1, 1'b0, 8'h01, 1'b0, 1'b1, "R10");
    step(1, 1, 1'b0, 8'h03, 1'b0, 1'b1, "R10");

    // R11: load applies only after the load edge
    cfg_i = 11'b000_0000_0010;
    cfg_ld_i = 1'b1;
    step(3, 1, 1'b1, 8'h99, 1'b0, 1'b0, "R11");
    cfg_ld_i = 1'b0;
    cfg_m = 11'b000_0000_0010;
    step(3, 1, 1'b1, 8'h99, 1'b0, 1'b0, "R11");

    // random
    for (int i = 0; i < 4000; i++) begin
      if (i % 100 == 0) begin
        load_cfg(11'($urandom));
        s1_reg_i = 8'($urandom);
        f1_reg_i = 8'($urandom);
        dflt_i   = 8'($urandom);
      end
      step(int'($urandom_range(0, 10)), int'($urandom_range(0, 10)),
           ($urandom_range(0, 9) != 0), 8'($urandom), 1'($urandom),
           1'($urandom), "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule